// File: doc/BRIEF.md
# Detector Job Dispatch Scheduler

This block sits in front of a pool of tree-search detector cores. Detection jobs, one per received symbol, arrive at a steady rate over a valid/ready input and are queued in an internal FIFO. Whenever the queue holds a job and at least one core reports itself idle, the oldest job is handed to the lowest-numbered idle core. The job goes out on a shared payload bus, with a one-hot strobe that picks the target core.

Each dispatched job comes with a node budget: the largest number of tree nodes the core may visit before it must give its best answer. While the queue is short, every job gets the full programmed budget. Once the queue passes a programmable start point, the budget falls linearly over a ramp of 2^RAMP_SHIFT entries, and it reaches the programmed floor at the end of that ramp. Cores then finish sooner, the queue drains, and the input is throttled only if the queue is completely full.

Each dispatch also carries a wrapping sequence tag. A later stage uses the tag to put results back in order, because the cores finish after varying numbers of cycles. A core must raise its busy flag in the cycle after it is strobed.

Top module: `dispatch_sched`

## Requirements
- R1: After reset, jobReady is 1, no dispatch strobe is raised, and the first dispatched job carries tag 0.
- R2: Jobs leave in the order they were accepted, with the payload unchanged. A job accepted at a clock edge may be dispatched in the cycle that follows that edge.
- R3: A job is only strobed to a core whose busy flag is low. When several cores are idle, the one with the lowest index is chosen.
- R4: At most one dispatch strobe is high in any cycle. No strobe is raised while the queue is empty.
- R5: jobReady is low exactly when the queue holds FIFO_DEPTH jobs. A job offered while jobReady is low is not accepted and never reaches a core.
- R6: The occupancy is the queue count in the dispatch cycle, including the job being dispatched. If occupancy is at or below rampStart, dispBudget equals budgetMax.
- R7: If occupancy is above rampStart by rel, with 0 < rel < 2^RAMP_SHIFT, dispBudget equals budgetMax − floor((budgetMax − budgetMin)·rel / 2^RAMP_SHIFT).
- R8: If occupancy is at least rampStart + 2^RAMP_SHIFT, dispBudget equals budgetMin.
- R9: The tag goes up by one with each dispatch and wraps modulo 2^TAG_W, where TAG_W = clog2(FIFO_DEPTH + NUM_CORES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jobValid | input | 1 | Incoming job is present |
| jobReady | output | 1 | Queue can accept a job |
| jobData | input | JOB_W | Incoming job payload |
| budgetMax | input | BUDGET_W | Budget used for a short queue |
| budgetMin | input | BUDGET_W | Budget floor for a long queue (must not exceed budgetMax) |
| rampStart | input | OCC_W | Occupancy at which the budget starts falling |
| coreBusy | input | NUM_CORES | Per-core busy flags |
| dispValid | output | NUM_CORES | One-hot dispatch strobe |
| dispData | output | JOB_W | Payload of the dispatched job |
| dispTag | output | TAG_W | Sequence tag of the dispatched job |
| dispBudget | output | BUDGET_W | Node budget of the dispatched job |

## Verification
The hardest states to reach are the deep-queue ones: a full queue, the budget floor, and the upper part of the ramp. Under normal arrivals the idle cores keep the queue short. The bench holds every core busy while it streams jobs in, so the queue fills to the brim and an extra job is offered against the low jobReady. It then releases the cores with varied service times, so that the queue drains through every occupancy value. Each dispatch is compared with the budget computed from the bench's own count of the queue. This is repeated over several settings of budgetMax, budgetMin and rampStart. Enough jobs pass through to wrap the tag.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } dsStrobe_t;
endpackage

// File: rtl/ds_datapath.sv
module ds_datapath
  import dispatch_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int JOB_W      = 8,
  parameter int BUDGET_W   = 10,
  parameter int RAMP_SHIFT = 3,
  parameter int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dsStrobe_t           strb,
  input  logic [JOB_W-1:0]    jobData,
  input  logic [BUDGET_W-1:0] budgetMax,
  input  logic [BUDGET_W-1:0] budgetMin,
  input  logic [OCC_W-1:0]    rampStart,
  output logic                fifoFull,
  output logic                fifoEmpty,
  output logic [JOB_W-1:0]    headData,
  output logic [BUDGET_W-1:0] budget
);
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int PROD_W = BUDGET_W + OCC_W;
  localparam int SPAN   = 1 << RAMP_SHIFT;

  logic [JOB_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= jobData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoFull  = (count == OCC_W'(FIFO_DEPTH));
  assign fifoEmpty = (count == '0);
  assign headData  = mem[rdPtr];

  // occupancy to budget mapping
  logic [BUDGET_W-1:0] diff;
  logic [OCC_W-1:0]    rel;
  logic [PROD_W-1:0]   prod;
  logic [PROD_W-1:0]   scaled;

  always_comb begin
    diff   = budgetMax - budgetMin;
    rel    = count - rampStart;
    prod   = {{OCC_W{1'b0}}, diff} * {{BUDGET_W{1'b0}}, rel};
    scaled = prod >> RAMP_SHIFT;
    if (count <= rampStart)           budget = budgetMax;
    else if (int'(rel) >= SPAN)       budget = budgetMin;
    else                              budget = budgetMax - scaled[BUDGET_W-1:0];
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= OCC_W'(FIFO_DEPTH));

  // R5
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push && fifoFull && !strb.pop));

  // R8
  budget_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && budgetMin <= budgetMax) |-> (budget >= budgetMin && budget <= budgetMax));
endmodule

// File: rtl/ds_ctrl.sv
module ds_ctrl
  import dispatch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TAG_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 jobValid,
  input  logic                 fifoFull,
  input  logic                 fifoEmpty,
  input  logic [NUM_CORES-1:0] coreBusy,
  output dsStrobe_t            strb,
  output logic                 jobReady,
  output logic [NUM_CORES-1:0] dispValid,
  output logic [TAG_W-1:0]     tagCnt
);
  logic found;

  always_comb begin
    dispValid = '0;
    found     = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (!coreBusy[c] && !found && !fifoEmpty) begin
        dispValid[c] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign jobReady  = !fifoFull;
  assign strb.push = jobValid && !fifoFull;
  assign strb.pop  = |dispValid;

  always_ff @(posedge clk) begin
    if (!rstN)         tagCnt <= '0;
    else if (strb.pop) tagCnt <= tagCnt + 1'b1;
  end

  // R4
  one_dispatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dispValid));
endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
  import dispatch_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int JOB_W      = 8,
  parameter int BUDGET_W   = 10,
  parameter int RAMP_SHIFT = 3,
  localparam int OCC_W     = $clog2(FIFO_DEPTH + 1),
  localparam int TAG_W     = $clog2(FIFO_DEPTH + NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 jobValid,
  output logic                 jobReady,
  input  logic [JOB_W-1:0]     jobData,
  input  logic [BUDGET_W-1:0]  budgetMax,
  input  logic [BUDGET_W-1:0]  budgetMin,
  input  logic [OCC_W-1:0]     rampStart,
  input  logic [NUM_CORES-1:0] coreBusy,
  output logic [NUM_CORES-1:0] dispValid,
  output logic [JOB_W-1:0]     dispData,
  output logic [TAG_W-1:0]     dispTag,
  output logic [BUDGET_W-1:0]  dispBudget
);
  dsStrobe_t strb;
  logic fifoFull, fifoEmpty;

  ds_ctrl #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .jobValid(jobValid), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .coreBusy(coreBusy), .strb(strb),
    .jobReady(jobReady), .dispValid(dispValid), .tagCnt(dispTag)
  );

  ds_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .JOB_W(JOB_W), .BUDGET_W(BUDGET_W),
                .RAMP_SHIFT(RAMP_SHIFT), .OCC_W(OCC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .jobData(jobData),
    .budgetMax(budgetMax), .budgetMin(budgetMin), .rampStart(rampStart),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headData(dispData),
    .budget(dispBudget)
  );

  // R4
  empty_dispatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> (dispValid == '0));
endmodule

// File: tb/dispatch_sched_tb.sv
module dispatch_sched_tb;
  localparam int NC = 4, DEPTH = 16, JW = 8, BW = 10, RS = 3;
  localparam int OW = $clog2(DEPTH + 1), TW = $clog2(DEPTH + NC);

  logic clk = 0, rstN = 0, jobValid = 0, jobReady;
  logic [JW-1:0] jobData = '0;
  logic [BW-1:0] budgetMax = 0, budgetMin = 0;
  logic [OW-1:0] rampStart = 0;
  logic [NC-1:0] coreBusy = '0, dispValid;
  logic [JW-1:0] dispData;
  logic [TW-1:0] dispTag;
  logic [BW-1:0] dispBudget;

  always #2 clk = ~clk;

  dispatch_sched #(.NUM_CORES(NC), .FIFO_DEPTH(DEPTH), .JOB_W(JW),
                   .BUDGET_W(BW), .RAMP_SHIFT(RS)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int q [$];
  int busyCnt [NC];
  int expTag = 0, occ = 0, seed = 7, nextData = 0;
  bit holdCores = 0;
  int arrivePct = 50;
  int sawExtra = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8) % m;
  endfunction

  function automatic int expBudget(input int o);
    int rel;
    if (o <= int'(rampStart)) return int'(budgetMax);
    rel = o - int'(rampStart);
    if (rel >= (1 << RS)) return int'(budgetMin);
    return int'(budgetMax) - (((int'(budgetMax) - int'(budgetMin)) * rel) >> RS);
  endfunction

  // one cycle: drive at negedge, sample, update model
  task automatic cycle(input bit offerExtra);
    int core, data;
    @(negedge clk);
    for (int c = 0; c < NC; c++) coreBusy[c] = holdCores || (busyCnt[c] != 0);
    if (offerExtra) begin
      jobValid = 1; jobData = 8'hEE;
    end else if (rnd(100) < arrivePct) begin
      jobValid = 1; jobData = JW'(nextData);
    end else jobValid = 0;
    #1;
    // R5: ready only drops when full
    chk(jobReady == (occ != DEPTH), "R5 ready", int'(jobReady), int'(occ != DEPTH));
    core = -1;
    if (occ > 0)
      for (int c = NC - 1; c >= 0; c--) if (!coreBusy[c]) core = c;
    if (core < 0) begin
      chk(dispValid == '0, "R4 no dispatch", int'(dispValid), 0);
    end else begin
      chk(dispValid == NC'(1 << core), "R3 lowest idle", int'(dispValid), 1 << core);
      chk(int'(dispData) == q[0], "R2 order", int'(dispData), q[0]);
      chk(int'(dispTag) == expTag, "R9 tag", int'(dispTag), expTag);
      chk(int'(dispBudget) == expBudget(occ), "R6 R7 R8 budget", int'(dispBudget), expBudget(occ));
    end
    if (offerExtra && !jobReady) sawExtra = 1;
    for (int c = 0; c < NC; c++) if (busyCnt[c] > 0) busyCnt[c]--;
    if (core >= 0) begin
      data = q.pop_front();
      if (data == 'hEE) chk(0, "R5 rejected job", data, 0);
      occ--;
      expTag = (expTag + 1) % (1 << TW);
      busyCnt[core] = 1 + rnd(6);
    end
    if (jobValid && jobReady) begin
      q.push_back(int'(jobData));
      occ++;
      if (!offerExtra) nextData = (nextData + 1) % 200;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) busyCnt[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1
    chk(jobReady == 1, "R1 reset ready", int'(jobReady), 1);
    chk(dispValid == '0, "R1 reset strobes", int'(dispValid), 0);
    rstN = 1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      case (cfg)
        0: begin budgetMax = 800; budgetMin = 100; rampStart = 4; end
        1: begin budgetMax = 1023; budgetMin = 0;  rampStart = 0; end
        2: begin budgetMax = 300; budgetMin = 299; rampStart = 8; end
        default: begin budgetMax = 50; budgetMin = 50; rampStart = 2; end
      endcase
      // fill with all cores held busy (R5, R8 deep queue)
      holdCores = 1; arrivePct = 100;
      while (occ < DEPTH) cycle(0);
      cycle(1);
      chk(sawExtra == 1, "R5 full ready low", sawExtra, 1);
      sawExtra = 0;
      holdCores = 0; arrivePct = 0;
      // drain through every occupancy (R6 R7 R8)
      while (occ > 0) cycle(0);
      // steady traffic (R2 R3 R9)
      arrivePct = 40 + 15 * cfg;
      repeat (300) cycle(0);
      arrivePct = 0;
      repeat (40) cycle(0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule